// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block picks which memory bank, and which controller machine, services an access on a memory controller that sits between a primary system bus and a secondary local bus. Every bank has a configuration entry with a base tag, a compare mask, a machine-select code and a valid bit. On each request the upper 17 address bits are masked and compared against every bank in parallel. The lowest-numbered bank that hits wins.

The winner's machine-select code names the controller machine and the bus on which that bank lives. For the three user-programmable machines, a per-machine bus bit makes the bus choice. A system-bus request that lands on a local-bus bank is handed to the local bus. A local-bus request whose winning bank lives on the system bus is dropped and reported as no match.

The decode is registered on the request strobe. A successful decode grants one machine and keeps that grant, with the bank index and the target bus, until a cycle-done input releases it. Requests that arrive while a grant is held are ignored.

Top module: `bank_decoder`

## Requirements
- R1: After synchronous active-low reset, `grant` is zero, `no_match` is low and every bank is invalid, so the first request yields a no-match result.
- R2: A valid bank hits when `req_addr[31:15] & mask == base`. Address bits outside the mask are don't-care. An invalid bank never hits.
- R3: When several banks hit, the lowest-numbered bank wins and is reported on `hit_bank`.
- R4: Machine-select codes are: 0 SDRAM on system bus, 1 SDRAM on local bus, 2 chip-select on system bus, 3 chip-select on local bus, 4/5/6 programmable machine 0/1/2, 7 reserved. A bank with code 7 never hits. `grant` is one-hot, with bit 0 for SDRAM, bit 1 for chip-select and bits 2..4 for programmable machines 0..2.
- R5: For codes 4..6, bit k of `upm_local` places programmable machine k on the local bus (1) or the system bus (0).
- R6: A system-bus request is granted whichever bus its winning bank is on. `tgt_local` is 1 when that bank is on the local bus.
- R7: A local-bus request whose winning bank is on the system bus gives no grant and a `no_match` pulse. A local-bus request whose winning bank is on the local bus is granted.
- R8: A request with no hitting bank gives a one-cycle `no_match` pulse and no grant.
- R9: Results appear in the clock cycle after the edge that samples `req`, and exactly one result is produced for each accepted request.
- R10: While a grant is held and `cycle_done` is low, `grant`, `hit_bank` and `tgt_local` stay stable. New requests are ignored. Configuration writes apply only from the next decode.
- R11: In the cycle after `cycle_done` is sampled high during a grant, `grant` returns to zero.
- R12: Configuration writes use `cfg_addr[4:1]` as the bank index. Word 0 (`cfg_addr[0]=0`) holds valid in bit 20, machine select in bits 19:17 and base in bits 16:0. Word 1 holds mask in bits 16:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Bank index and word select |
| cfg_wdata | input | 21 | Configuration write data |
| upm_local | input | 3 | Bus bit per programmable machine (1 = local) |
| req | input | 1 | Access request strobe |
| req_local | input | 1 | Request comes from the local bus |
| req_addr | input | 32 | Access address |
| cycle_done | input | 1 | Current cycle has finished; release the grant |
| grant | output | 5 | One-hot machine ownership |
| hit_bank | output | 4 | Winning bank index while granted |
| tgt_local | output | 1 | Granted access is serviced on the local bus |
| no_match | output | 1 | One-cycle pulse: request dropped or missed |

## Verification
A wrong winner index or routing flag shows on the ports in the cycle right after the request as a wrong `grant` bit, a wrong `hit_bank` or an unexpected `no_match`. The scoreboard compares every such result with an independently predicted value. A corrupted ownership state shows as a grant that changes, appears or persists while `cycle_done` is low or just after it rises. The bench checks this every cycle during a deliberately long held cycle, with a stray request and configuration writes applied inside that cycle.

// File: rtl/bank_dec_pkg.sv
// Shared types for the bank decoder: machine-select codes, the per-bank
// configuration record and helpers mapping a code to its machine and bus.
package bank_dec_pkg;
    localparam int FIELD_W  = 17;
    localparam int NUM_MACH = 5;
    localparam int CFG_DW   = FIELD_W + 4;

    typedef enum logic [2:0] {
        MS_SDR_SYS = 3'd0,
        MS_SDR_LOC = 3'd1,
        MS_CS_SYS  = 3'd2,
        MS_CS_LOC  = 3'd3,
        MS_PM0     = 3'd4,
        MS_PM1     = 3'd5,
        MS_PM2     = 3'd6,
        MS_RSVD    = 3'd7
    } msel_e;

    typedef struct packed {
        logic               valid;
        msel_e              msel;
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] mask;
    } bank_cfg_t;

    // One-hot machine vector for a select code (zero for reserved).
    function automatic logic [NUM_MACH-1:0] msel_to_grant(input msel_e m);
        case (m)
            MS_SDR_SYS, MS_SDR_LOC: msel_to_grant = 5'b00001;
            MS_CS_SYS,  MS_CS_LOC:  msel_to_grant = 5'b00010;
            MS_PM0:                 msel_to_grant = 5'b00100;
            MS_PM1:                 msel_to_grant = 5'b01000;
            MS_PM2:                 msel_to_grant = 5'b10000;
            default:                msel_to_grant = 5'b00000;
        endcase
    endfunction

    // True when a bank with this select code lives on the local bus.
    function automatic logic msel_on_local(input msel_e m, input logic [2:0] pm_loc);
        case (m)
            MS_SDR_LOC, MS_CS_LOC: msel_on_local = 1'b1;
            MS_PM0:                msel_on_local = pm_loc[0];
            MS_PM1:                msel_on_local = pm_loc[1];
            MS_PM2:                msel_on_local = pm_loc[2];
            default:               msel_on_local = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/bank_cfg_regs.sv
// Per-bank configuration storage. Word 0 of a bank carries valid, select
// and base; word 1 carries the mask. Assumes writes to bank indices at or
// above NUM_BANKS are simply dropped.
module bank_cfg_regs
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int CFG_AW    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [CFG_AW-1:0]           waddr,
    input  logic [CFG_DW-1:0]           wdata,
    output bank_cfg_t [NUM_BANKS-1:0]   cfg
);
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            bank_cfg_t q;
            logic      sel;

            assign sel    = we && (waddr[CFG_AW-1:1] == (CFG_AW-1)'(b));
            assign cfg[b] = q;

            // Load the addressed word of this bank; reset leaves it invalid.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (sel) begin
                    if (!waddr[0]) begin
                        q.valid <= wdata[CFG_DW-1];
                        q.msel  <= msel_e'(wdata[FIELD_W+2:FIELD_W]);
                        q.base  <= wdata[FIELD_W-1:0];
                    end else begin
                        q.mask  <= wdata[FIELD_W-1:0];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bank_match.sv
// Parallel masked compare of the request tag against all banks followed by
// a lowest-index priority pick. Assumes the reserved select code disables
// a bank just like a cleared valid bit.
module bank_match
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int IDX_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  bank_cfg_t [NUM_BANKS-1:0]   cfg,
    input  logic [FIELD_W-1:0]          tag,
    output logic [NUM_BANKS-1:0]        hit_vec,
    output logic                        any_hit,
    output logic [IDX_W-1:0]            win_idx
);
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
            assign hit_vec[b] = cfg[b].valid && (cfg[b].msel != MS_RSVD)
                                && ((tag & cfg[b].mask) == cfg[b].base);
        end
    endgenerate

    // Priority pick: scan downward so the lowest hitting index is kept.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    a_r3_winner_hits: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit_vec[win_idx]);
    a_r3_no_lower_hit: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((hit_vec & ~({NUM_BANKS{1'b1}} << win_idx)) == '0));
    a_r8_none_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> !any_hit);
endmodule

// File: rtl/bank_route.sv
// Bus routing for a decoded winner: system-bus requests are always
// serviced (on the bank's bus); local-bus requests that win a system-bus
// bank are dropped. Purely combinational.
module bank_route
    import bank_dec_pkg::*;
(
    input  logic                  any_hit,
    input  msel_e                 win_msel,
    input  logic                  req_local,
    input  logic [2:0]            pm_loc,
    output logic                  accept,
    output logic                  tgt_local,
    output logic [NUM_MACH-1:0]   mach
);
    logic bank_local;

    // Decide acceptance, the servicing bus and the machine to own the cycle.
    always_comb begin
        bank_local = msel_on_local(win_msel, pm_loc);
        accept     = any_hit && !(req_local && !bank_local);
        tgt_local  = bank_local;
        mach       = accept ? msel_to_grant(win_msel) : '0;
    end
endmodule

// File: rtl/bank_decoder.sv
// Top of the bank decoder: configuration storage, parallel match, bus
// routing and the ownership register that holds a grant until the cycle
// finishes. Assumes one request strobe per access and that requests seen
// while a grant is held may be discarded by the requester's protocol.
module bank_decoder
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = $clog2(NUM_BANKS),
    parameter int CFG_AW    = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0]     cfg_wdata,
    input  logic [2:0]            upm_local,
    input  logic                  req,
    input  logic                  req_local,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  cycle_done,
    output logic [NUM_MACH-1:0]   grant,
    output logic [IDX_W-1:0]      hit_bank,
    output logic                  tgt_local,
    output logic                  no_match
);
    localparam int LOW_W = ADDR_W - FIELD_W;

    bank_cfg_t [NUM_BANKS-1:0] cfg;
    logic [NUM_BANKS-1:0]      hit_vec;
    logic                      any_hit;
    logic [IDX_W-1:0]          win_idx;
    logic                      accept;
    logic                      route_local;
    logic [NUM_MACH-1:0]       mach;
    logic                      unused_low;

    logic                      busy_q;
    logic [NUM_MACH-1:0]       grant_q;
    logic [IDX_W-1:0]          bank_q;
    logic                      local_q;
    logic                      miss_q;

    assign unused_low = ^req_addr[LOW_W-1:0];

    bank_cfg_regs #(.NUM_BANKS(NUM_BANKS), .CFG_AW(CFG_AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    bank_match #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .tag     (req_addr[ADDR_W-1:LOW_W]),
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    bank_route u_route (
        .any_hit   (any_hit),
        .win_msel  (cfg[win_idx].msel),
        .req_local (req_local),
        .pm_loc    (upm_local),
        .accept    (accept),
        .tgt_local (route_local),
        .mach      (mach)
    );

    // Ownership register: capture on an idle request, hold, release on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            grant_q <= '0;
            bank_q  <= '0;
            local_q <= 1'b0;
            miss_q  <= 1'b0;
        end else begin
            miss_q <= 1'b0;
            if (busy_q) begin
                if (cycle_done) begin
                    busy_q  <= 1'b0;
                    grant_q <= '0;
                    bank_q  <= '0;
                    local_q <= 1'b0;
                end
            end else if (req) begin
                if (accept) begin
                    busy_q  <= 1'b1;
                    grant_q <= mach;
                    bank_q  <= win_idx;
                    local_q <= route_local;
                end else begin
                    miss_q  <= 1'b1;
                end
            end
        end
    end

    assign grant     = grant_q;
    assign hit_bank  = bank_q;
    assign tgt_local = local_q;
    assign no_match  = miss_q;

    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r8_miss_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> (grant == '0));
    a_r9_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !req) |=> ((grant == '0) && !no_match));
    a_r10_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !cycle_done) |=> ($stable(grant) && $stable(hit_bank) && $stable(tgt_local)));
    a_r10_no_miss_while_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !cycle_done) |=> !no_match);
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cycle_done) |=> (grant == '0));
endmodule

// File: tb/tb_bank_decoder.sv
// Scoreboard bench: the access task predicts each result and queues it,
// the monitor pops and compares whenever the design produces a result.
module tb_bank_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [20:0] cfg_wdata = '0;
    logic [2:0]  upm_local = '0;
    logic        req = 1'b0;
    logic        req_local = 1'b0;
    logic [31:0] req_addr = '0;
    logic        cycle_done = 1'b0;
    logic [4:0]  grant;
    logic [3:0]  hit_bank;
    logic        tgt_local;
    logic        no_match;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [10:0] exp_q[$];
    string       tag_q[$];
    logic [4:0]  prev_grant = '0;

    logic        m_valid[12];
    logic [2:0]  m_msel[12];
    logic [16:0] m_base[12];
    logic [16:0] m_mask[12];

    always #5 clk = ~clk;

    bank_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .upm_local(upm_local), .req(req),
        .req_local(req_local), .req_addr(req_addr), .cycle_done(cycle_done),
        .grant(grant), .hit_bank(hit_bank), .tgt_local(tgt_local),
        .no_match(no_match)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Result predicted from the requirements: {no_match, tgt_local, bank, grant}.
    function automatic logic [10:0] predict(input logic [16:0] t, input logic loc);
        int    win = -1;
        logic  bl;
        logic [4:0] g;
        for (int i = 0; i < 12; i++)
            if (win < 0 && m_valid[i] && m_msel[i] != 3'd7 && ((t & m_mask[i]) == m_base[i]))
                win = i;
        if (win < 0) return {1'b1, 1'b0, 4'd0, 5'd0};
        case (m_msel[win])
            3'd1, 3'd3: bl = 1'b1;
            3'd4: bl = upm_local[0];
            3'd5: bl = upm_local[1];
            3'd6: bl = upm_local[2];
            default: bl = 1'b0;
        endcase
        if (loc && !bl) return {1'b1, 1'b0, 4'd0, 5'd0};
        case (m_msel[win])
            3'd0, 3'd1: g = 5'b00001;
            3'd2, 3'd3: g = 5'b00010;
            3'd4: g = 5'b00100;
            3'd5: g = 5'b01000;
            default: g = 5'b10000;
        endcase
        return {1'b0, bl, 4'(win), g};
    endfunction

    task automatic write_bank(input int b, input logic v, input logic [2:0] ms,
                              input logic [16:0] base, input logic [16:0] mask);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {4'(b), 1'b0}; cfg_wdata = {v, ms, base};
        @(negedge clk);
        cfg_addr = {4'(b), 1'b1}; cfg_wdata = {4'd0, mask};
        @(negedge clk);
        cfg_we = 1'b0;
        m_valid[b] = v; m_msel[b] = ms; m_base[b] = base; m_mask[b] = mask;
    endtask

    task automatic access(input logic [16:0] t, input logic loc, input string tag);
        logic [10:0] e;
        @(negedge clk);
        req = 1'b1; req_local = loc; req_addr = {t, 15'h1234};
        e = predict(t, loc);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
        // R9: a result must be visible in the cycle after the sampling edge
        chk((grant != 0) || no_match, {"R9 latency ", tag}, {grant, no_match}, 1);
        if (e[4:0] != 0) begin
            repeat (2) @(negedge clk);
            cycle_done = 1'b1;
            @(negedge clk);
            cycle_done = 1'b0;
            chk(grant == 0, {"R11 release ", tag}, grant, 0);
        end
    endtask

    // Monitor: compare each new result against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && (no_match || (grant != 0 && prev_grant == 0))) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected result", {no_match, tgt_local, hit_bank, grant}, 0);
            end else begin
                logic [10:0] e;
                string       tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk({no_match, tgt_local, hit_bank, grant} == e, tg,
                    {no_match, tgt_local, hit_bank, grant}, e);
            end
        end
        prev_grant <= grant;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) begin
            m_valid[i] = 0; m_msel[i] = 0; m_base[i] = 0; m_mask[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grant == 0 && !no_match, "R1 reset outputs", {grant, no_match}, 0);
        access(17'h01000, 1'b0, "R1 all banks invalid");

        upm_local = 3'b010;
        write_bank(0, 1, 3'd0, 17'h01000, 17'h1F000);
        write_bank(1, 1, 3'd2, 17'h02000, 17'h1FFFF);
        write_bank(2, 1, 3'd1, 17'h03000, 17'h1FF00);
        write_bank(3, 1, 3'd3, 17'h03000, 17'h1F000);
        write_bank(4, 1, 3'd4, 17'h04000, 17'h1FFFF);
        write_bank(5, 1, 3'd5, 17'h05000, 17'h1FFFF);
        write_bank(6, 1, 3'd6, 17'h06000, 17'h1FFFF);
        write_bank(7, 0, 3'd0, 17'h07000, 17'h1FFFF);
        write_bank(8, 1, 3'd7, 17'h08000, 17'h1FFFF);
        write_bank(9, 1, 3'd2, 17'h0A800, 17'h1FF00);
        write_bank(11, 1, 3'd0, 17'h0A000, 17'h1F000);

        access(17'h01000, 1'b0, "R2 R12 base hit");
        access(17'h01ABC, 1'b0, "R2 masked bits ignored");
        access(17'h07000, 1'b0, "R2 invalid bank");
        access(17'h08000, 1'b0, "R4 reserved code");
        access(17'h02000, 1'b0, "R4 chip-select machine");
        access(17'h04000, 1'b0, "R4 machine 0");
        access(17'h06000, 1'b0, "R4 machine 2");
        access(17'h03010, 1'b0, "R3 R6 overlap lower wins");
        access(17'h03100, 1'b0, "R3 R6 only upper hits");
        access(17'h0A800, 1'b0, "R3 bank9 over bank11");
        access(17'h0A100, 1'b0, "R3 bank11 alone");
        access(17'h05000, 1'b1, "R5 machine 1 on local");
        access(17'h04000, 1'b1, "R5 R7 machine 0 on system");
        access(17'h03010, 1'b1, "R7 local to local bank");
        access(17'h02000, 1'b1, "R7 local to system bank");
        access(17'h1F000, 1'b0, "R8 no bank system");
        access(17'h1F000, 1'b1, "R8 no bank local");
        upm_local = 3'b001;
        access(17'h04000, 1'b1, "R5 machine 0 moved local");

        // R10: long held cycle with a stray request and a config rewrite
        @(negedge clk);
        req = 1'b1; req_local = 1'b0; req_addr = {17'h02000, 15'h0};
        exp_q.push_back(predict(17'h02000, 1'b0)); tag_q.push_back("R10 held grant");
        @(negedge clk);
        req = 1'b0;
        chk(grant == 5'b00010 && hit_bank == 4'd1, "R10 grant taken", {hit_bank, grant}, {4'd1, 5'b00010});
        req = 1'b1; req_addr = {17'h04000, 15'h0};
        @(negedge clk);
        req = 1'b0;
        chk(grant == 5'b00010 && hit_bank == 4'd1 && !no_match, "R10 stray request ignored",
            {no_match, hit_bank, grant}, {1'b0, 4'd1, 5'b00010});
        write_bank(1, 1, 3'd0, 17'h02000, 17'h1FFFF);
        chk(grant == 5'b00010 && hit_bank == 4'd1 && !tgt_local, "R10 config write held off",
            {tgt_local, hit_bank, grant}, {1'b0, 4'd1, 5'b00010});
        cycle_done = 1'b1;
        @(negedge clk);
        cycle_done = 1'b0;
        chk(grant == 0, "R11 release after hold", grant, 0);
        access(17'h02000, 1'b0, "R10 new config on next decode");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 every request answered", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule